// File: doc/BRIEF.md
# Three-Wire Configuration Register Port

This block is a write-only serial control port. It fills a small bank of configuration registers for an eight-channel audio converter core. A host lowers the active-low select line and clocks in one 16-bit frame, most significant bit first. The frame holds a two-bit device address, a direction flag, a five-bit register index and one data byte. When select rises again, the block checks the frame and either commits the byte or drops the frame.

The select, clock and data pins are not tied to the core clock. Each passes through a two-stage synchroniser, and the block finds the edges in the core domain. The decoded fields are presented as core-domain outputs that hold their reset defaults until a frame overwrites them. The DAC 1 power-enable bit has two addresses. It is one physical flop, so a write to either address changes it.

Top module: `serial_cfg_port`

## Requirements
- R1: After reset the outputs read as follows. auto_clk=1, tdm_sel=0, fmt_sel=2, tim_run=1, slow_rolloff=0, speed_sel=0, deemph_sel=1, soft_mute=0, pwr_dac=4'hF, zero_pol=0, every level byte 8'hFF, and invert, zmask_a, zmask_b and deemph_en all 0.
- R2: Frame bits from first to last are: device-address high, device-address low, direction, index[4:0], data[7:0]. A bit is sampled on each sclk rising edge while cs_n is low. The write is committed only after cs_n rises.
- R3: A frame is dropped, with no output changing, unless its first bit equals addr_strap and its second bit is 1.
- R4: A frame whose direction bit is 0 is dropped, with no output changing.
- R5: A frame with index 0x0F to 0x1F is dropped, with no output changing.
- R6: A frame is dropped, with no output changing, if cs_n rises after any bit count other than exactly 16, fewer or more.
- R7: pwr_dac[0] is written from data bit 1 of a valid write to index 0x00 and also from data bit 1 of a valid write to index 0x02.
- R8: Index 0x00 maps as auto_clk=d[7], tdm_sel=d[6:5], fmt_sel=d[4:2], pwr_dac[0]=d[1], tim_run=d[0]. Index 0x01 maps as slow_rolloff=d[5], speed_sel=d[4:3], deemph_sel=d[2:1], soft_mute=d[0]. Index 0x02 maps as pwr_dac[3:1]=d[7:5] and zero_pol=d[2].
- R9: Indexes 0x03 to 0x0A load level byte k = index minus 3, stored at level_codes[8k+7:8k]. Index 0x0B loads invert. Index 0x0C loads zmask_a. Index 0x0D loads zmask_b. Index 0x0E loads deemph_en from d[3:0].
- R10: Clearing tim_run changes no other output. Every register still accepts writes while tim_run and pwr_dac are 0.
- R11: No output changes while a frame is still being clocked in with cs_n low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial bit clock |
| sdi | input | 1 | Serial data |
| addr_strap | input | 1 | Strap that the high device-address bit must match |
| auto_clk | output | 1 | Automatic clock-ratio detection enable |
| tdm_sel | output | 2 | Time-division multiplex mode |
| fmt_sel | output | 3 | Audio data format |
| tim_run | output | 1 | Internal timing run (0 = timing held in reset) |
| slow_rolloff | output | 1 | Slow roll-off filter select |
| speed_sel | output | 2 | Sampling speed |
| deemph_sel | output | 2 | De-emphasis response |
| soft_mute | output | 1 | Soft mute |
| pwr_dac | output | 4 | Per-DAC power enable |
| zero_pol | output | 1 | Zero-flag polarity |
| level_codes | output | 64 | Eight channel level bytes |
| invert | output | 8 | Per-channel output inversion |
| zmask_a | output | 8 | Channel mask for the first zero flag |
| zmask_b | output | 8 | Channel mask for the second zero flag |
| deemph_en | output | 4 | Per-DAC de-emphasis enable |

## Verification
The assertions check on every cycle that outputs only move in the cycle after a select rising edge, which covers R11. They also check that no output moves after a frame that fails the address, direction, index or length tests, and that a committed write to either mirrored index lands in the shared power bit. Only the bench scenarios can show the field positions and reset values. The same holds for the level-byte placement, the exact values a valid frame leaves behind, and the rule that clearing the timing bit leaves every other register as it was.

// File: rtl/serial_cfg_port.sv
module serial_cfg_port #(
  parameter int NUM_LVL   = 8,
  parameter int FRAME_LEN = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cs_n,
  input  logic                   sclk,
  input  logic                   sdi,
  input  logic                   addr_strap,
  output logic                   auto_clk,
  output logic [1:0]             tdm_sel,
  output logic [2:0]             fmt_sel,
  output logic                   tim_run,
  output logic                   slow_rolloff,
  output logic [1:0]             speed_sel,
  output logic [1:0]             deemph_sel,
  output logic                   soft_mute,
  output logic [3:0]             pwr_dac,
  output logic                   zero_pol,
  output logic [8*NUM_LVL-1:0]   level_codes,
  output logic [7:0]             invert,
  output logic [7:0]             zmask_a,
  output logic [7:0]             zmask_b,
  output logic [3:0]             deemph_en
);
  localparam int CW        = $clog2(FRAME_LEN + 2);
  localparam int LVL_BASE  = 3;
  localparam int INV_ADDR  = LVL_BASE + NUM_LVL;
  localparam int ZA_ADDR   = INV_ADDR + 1;
  localparam int ZB_ADDR   = INV_ADDR + 2;
  localparam int DEM_ADDR  = INV_ADDR + 3;

  logic cs_m, cs_s, cs_d, ck_m, ck_s, ck_d, sd_m, sd_s;
  logic [FRAME_LEN-1:0] shreg;
  logic [CW-1:0]        bitcnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      {cs_m, cs_s, cs_d} <= 3'b111;
      {ck_m, ck_s, ck_d} <= 3'b111;
      {sd_m, sd_s}       <= 2'b00;
    end else begin
      {cs_m, cs_s, cs_d} <= {cs_n, cs_m, cs_s};
      {ck_m, ck_s, ck_d} <= {sclk, ck_m, ck_s};
      {sd_m, sd_s}       <= {sdi, sd_m};
    end

  wire cs_fall = !cs_s && cs_d;
  wire cs_rise = cs_s && !cs_d;
  wire ck_rise = ck_s && !ck_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      shreg  <= '0;
      bitcnt <= '0;
    end else if (cs_fall) begin
      bitcnt <= '0;
    end else if (!cs_s && ck_rise) begin
      shreg <= {shreg[FRAME_LEN-2:0], sd_s};
      if (bitcnt != '1) bitcnt <= bitcnt + 1'b1;
    end

  wire [4:0] wa = shreg[12:8];
  wire [7:0] wd = shreg[7:0];
  wire wr_en = cs_rise && (bitcnt == CW'(FRAME_LEN)) && (shreg[15] == addr_strap)
               && shreg[14] && shreg[13] && (wa <= 5'(DEM_ADDR));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      auto_clk     <= 1'b1;
      tdm_sel      <= 2'd0;
      fmt_sel      <= 3'd2;
      tim_run      <= 1'b1;
      slow_rolloff <= 1'b0;
      speed_sel    <= 2'd0;
      deemph_sel   <= 2'd1;
      soft_mute    <= 1'b0;
      pwr_dac      <= 4'hF;
      zero_pol     <= 1'b0;
      invert       <= '0;
      zmask_a      <= '0;
      zmask_b      <= '0;
      deemph_en    <= '0;
    end else if (wr_en) begin
      case (wa)
        5'd0: begin
          auto_clk   <= wd[7];
          tdm_sel    <= wd[6:5];
          fmt_sel    <= wd[4:2];
          pwr_dac[0] <= wd[1];
          tim_run    <= wd[0];
        end
        5'd1: begin
          slow_rolloff <= wd[5];
          speed_sel    <= wd[4:3];
          deemph_sel   <= wd[2:1];
          soft_mute    <= wd[0];
        end
        5'd2: begin
          pwr_dac  <= {wd[7:5], wd[1]};
          zero_pol <= wd[2];
        end
        5'(INV_ADDR): invert    <= wd;
        5'(ZA_ADDR):  zmask_a   <= wd;
        5'(ZB_ADDR):  zmask_b   <= wd;
        5'(DEM_ADDR): deemph_en <= wd[3:0];
        default: ;
      endcase
    end

  for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
    logic [7:0] lvl_q;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) lvl_q <= 8'hFF;
      else if (wr_en && wa == 5'(LVL_BASE + g)) lvl_q <= wd;
    assign level_codes[8*g +: 8] = lvl_q;
  end
endmodule

// File: rtl/serial_cfg_port_chk.sv
module serial_cfg_port_chk #(
  parameter int SNAP_W = 110
) (
  input logic              clk,
  input logic              rst_n,
  input logic              addr_strap,
  input logic              cs_s,
  input logic              cs_d,
  input logic [4:0]        bitcnt,
  input logic [15:0]       shreg,
  input logic [3:0]        pwr_dac,
  input logic [SNAP_W-1:0] snap
);
  wire fire = cs_s && !cs_d;
  wire good = fire && bitcnt == 5'd16 && shreg[15] == addr_strap && shreg[14] && shreg[13];

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(snap));
  assert_chip_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fire && (shreg[15] != addr_strap || !shreg[14]) |=> $stable(snap));
  assert_dir_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !shreg[13] |=> $stable(snap));
  assert_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fire && shreg[12:8] > 5'd14 |=> $stable(snap));
  assert_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fire && bitcnt != 5'd16 |=> $stable(snap));
  assert_mirror_R7: assert property (@(posedge clk) disable iff (!rst_n)
    good && (shreg[12:8] == 5'd0 || shreg[12:8] == 5'd2) |=> pwr_dac[0] == $past(shreg[1]));
endmodule

bind serial_cfg_port serial_cfg_port_chk chk_i (
  .clk(clk), .rst_n(rst_n), .addr_strap(addr_strap),
  .cs_s(cs_s), .cs_d(cs_d), .bitcnt(bitcnt), .shreg(shreg), .pwr_dac(pwr_dac),
  .snap({auto_clk, tdm_sel, fmt_sel, tim_run, slow_rolloff, speed_sel, deemph_sel,
         soft_mute, pwr_dac, zero_pol, level_codes, invert, zmask_a, zmask_b, deemph_en})
);

// File: tb/serial_cfg_port_tb_top.sv
`timescale 1ns/1ps
module serial_cfg_port_tb_top;
  logic clk = 0, rst_n = 0, cs_n = 1, sclk = 1, sdi = 0, addr_strap = 0;
  logic auto_clk, tim_run, slow_rolloff, soft_mute, zero_pol;
  logic [1:0] tdm_sel, speed_sel, deemph_sel;
  logic [2:0] fmt_sel;
  logic [3:0] pwr_dac, deemph_en;
  logic [63:0] level_codes;
  logic [7:0] invert, zmask_a, zmask_b;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  serial_cfg_port dut_i (.*);

  typedef struct { logic [109:0] v; string tag; } item_t;
  item_t q[$];
  logic [7:0] m [15];

  function automatic logic [109:0] exp_vec();
    logic [63:0] lv;
    for (int i = 0; i < 8; i++) lv[8*i +: 8] = m[3+i];
    return {m[0][7], m[0][6:5], m[0][4:2], m[0][0], m[1][5], m[1][4:3], m[1][2:1], m[1][0],
            m[2][7:5], m[0][1], m[2][2], lv, m[11], m[12], m[13], m[14][3:0]};
  endfunction

  function automatic logic [109:0] dut_vec();
    return {auto_clk, tdm_sel, fmt_sel, tim_run, slow_rolloff, speed_sel, deemph_sel,
            soft_mute, pwr_dac, zero_pol, level_codes, invert, zmask_a, zmask_b, deemph_en};
  endfunction

  function automatic logic [15:0] frm(input bit c1, input bit c0, input bit dir,
                                      input logic [4:0] a, input logic [7:0] d);
    return {c1, c0, dir, a, d};
  endfunction

  task automatic push(input string tag);
    item_t it;
    it.v = exp_vec();
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic send(input logic [31:0] bits, input int n, input string tag);
    logic [15:0] f;
    @(negedge clk) cs_n = 0;
    repeat (4) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      sdi = bits[i]; sclk = 0;
      repeat (4) @(negedge clk);
      sclk = 1;
      repeat (4) @(negedge clk);
    end
    push({"R11 hold before select rise / ", tag});
    repeat (2) @(negedge clk);
    cs_n = 1;
    repeat (8) @(negedge clk);
    f = bits[15:0];
    if (n == 16 && f[15] == addr_strap && f[14] && f[13] && f[12:8] <= 5'd14) begin
      m[f[12:8]] = f[7:0];
      if (f[12:8] == 5'd0) m[2][1] = f[1];
      if (f[12:8] == 5'd2) m[0][1] = f[1];
    end
    push(tag);
  endtask

  initial forever begin
    item_t it;
    @(negedge clk);
    while (q.size() > 0) begin
      it = q.pop_front();
      checks++;
      if (dut_vec() !== it.v) begin
        fails++;
        $display("FAIL %s act=%h exp=%h", it.tag, dut_vec(), it.v);
      end
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    m[0] = 8'h8B; m[1] = 8'h02; m[2] = 8'hE2;
    for (int i = 3; i <= 10; i++) m[i] = 8'hFF;
    for (int i = 11; i <= 14; i++) m[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    push("R1 reset defaults");
    send(frm(0, 1, 1, 5'd1, 8'h3F), 16, "R8 R2 control byte 1");
    send(frm(0, 1, 1, 5'd0, 8'h74), 16, "R8 R7 R10 control byte 0, timing cleared");
    send(frm(0, 1, 1, 5'd2, 8'h06), 16, "R7 R8 power byte mirrors DAC1 bit");
    for (int i = 0; i < 8; i++)
      send(frm(0, 1, 1, 5'(3 + i), 8'(8'h13 + 8'h21 * i)), 16, "R9 level byte");
    send(frm(0, 1, 1, 5'd11, 8'hA5), 16, "R9 invert");
    send(frm(0, 1, 1, 5'd12, 8'h3C), 16, "R9 zero mask a");
    send(frm(0, 1, 1, 5'd13, 8'hC3), 16, "R9 zero mask b");
    send(frm(0, 1, 1, 5'd14, 8'hFA), 16, "R9 de-emphasis enables");
    send(frm(0, 1, 1, 5'd2, 8'h00), 16, "R10 all DACs powered down");
    send(frm(0, 1, 1, 5'd0, 8'h00), 16, "R10 timing and DAC1 cleared");
    send(frm(0, 1, 1, 5'd5, 8'h42), 16, "R10 write accepted while powered down");
    send(frm(1, 1, 1, 5'd5, 8'h00), 16, "R3 high address bit mismatch");
    send(frm(0, 0, 1, 5'd5, 8'h00), 16, "R3 low address bit zero");
    send(frm(0, 1, 0, 5'd5, 8'h00), 16, "R4 direction bit zero");
    send(frm(0, 1, 1, 5'h0F, 8'h00), 16, "R5 index 0x0F");
    send(frm(0, 1, 1, 5'h1F, 8'h00), 16, "R5 index 0x1F");
    send({17'd0, frm(0, 1, 1, 5'd4, 8'h00) >> 1}, 15, "R6 short frame");
    send({16'd0, 1'b0, frm(0, 1, 1, 5'd4, 8'h00)}, 17, "R6 long frame");
    addr_strap = 1;
    send(frm(1, 1, 1, 5'd4, 8'h77), 16, "R3 strap high, matching frame");
    send(frm(0, 1, 1, 5'd4, 8'h00), 16, "R3 strap high, mismatching frame");
    send(frm(1, 1, 1, 5'd0, 8'h8B), 16, "R7 R2 control byte 0 restored");
    repeat (4) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule